// File: doc/BRIEF.md
# External Conversion Trigger Detector

This block turns an outside trigger signal into start requests for a converter sequencer. The trigger arrives on the digital copy of the highest-numbered analog pad, so the pad vector comes in whole and the block uses only its top bit. That pin is asynchronous. It passes through a two-flop synchronizer, and all detection works on the synchronized copy.

A two-bit sensitivity code chooses what counts as a trigger. Bit 1 selects level (1) or edge (0) sensitivity, and bit 0 selects the active polarity. The codes are: 00 falling edge, 01 rising edge, 10 low level, 11 high level.

In edge mode an active edge gives a single-cycle start pulse, but only when the sequencer reports idle. An edge that arrives while the sequencer is busy starts nothing and sets a sticky overrun flag. A one-cycle clear strobe removes that flag. In level mode the request is held high for as long as the active level lasts, so sequences follow one another back to back. An enable input gates the whole function. Any change of the enable or of the sensitivity code resets the edge history, so a reconfiguration cannot create an edge of its own.

Top module: `ext_trig_det`

## Requirements
- R1: After reset, `start_req` and `ovr_flag` are both 0.
- R2: With code 01 and the block enabled and idle, a pin change from 0 to 1 gives `start_req` = 1 after the third rising clock edge that follows the change, and not before.
- R3: With code 00, a 1-to-0 pin transition produces a start pulse and a 0-to-1 transition produces none.
- R4: With code 11, `start_req` is high for as long as the synchronized pin is 1, including while `seq_busy` is high. With code 10 it is high while the synchronized pin is 0. Level mode never sets `ovr_flag`.
- R5: In edge mode, each start pulse lasts exactly one clock cycle.
- R6: While `trig_en` is 0, pin activity drives neither `start_req` nor `ovr_flag`. Setting `trig_en` while the pin already sits at the active level produces no edge pulse.
- R7: In edge mode, an active edge detected while `seq_busy` is 1 produces no start pulse and sets `ovr_flag` one cycle after detection.
- R8: `ovr_flag` stays set until a cycle with `ovr_clr` = 1. If a new overrun occurs in the same cycle as the clear, the flag stays set.
- R9: A change of `sense_sel` in the cycle in which the synchronized pin changes produces no start pulse.
- R10: The pad bits below the highest one have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pad_in | input | NUM_CH | Digital copies of the analog pads; only the top bit is the trigger |
| trig_en | input | 1 | Trigger enable |
| sense_sel | input | 2 | Sensitivity code: bit 1 level/edge, bit 0 polarity |
| seq_busy | input | 1 | Sequencer is running a conversion sequence |
| ovr_clr | input | 1 | Clear strobe for the overrun flag |
| start_req | output | 1 | Start request: a pulse in edge mode, held in level mode |
| ovr_flag | output | 1 | Sticky trigger overrun flag |

## Verification
The assertions assume that `trig_en`, `sense_sel`, `seq_busy` and `ovr_clr` are synchronous to `clk`, and that only the top pad bit is asynchronous. They also assume `seq_busy` is a level reported by the sequencer, so its value in the detection cycle decides whether an edge starts a sequence or is counted as an overrun. The stimulus changes every input on the falling clock edge and holds it across the following rising edges. This places each pin transition, busy window and clear strobe in a known cycle relative to the synchronizer.

// File: rtl/ext_trig_pkg.sv
package ext_trig_pkg;

    // bit 1 picks level sensitivity, bit 0 picks the active value
    typedef enum logic [1:0] {
        SENSE_FALL = 2'b00,
        SENSE_RISE = 2'b01,
        SENSE_LOW  = 2'b10,
        SENSE_HIGH = 2'b11
    } sense_e;

    function automatic logic sense_is_level(sense_e m);
        return m[1];
    endfunction

    function automatic logic sense_active_val(sense_e m);
        return m[0];
    endfunction

endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    localparam int TOP = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] pipe;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe = {st_q.pipe[TOP-1:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.pipe[TOP];
endmodule

// File: rtl/trig_sense.sv
module trig_sense
    import ext_trig_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   lvl_in,
    input  logic   en,
    input  sense_e mode,
    input  logic   busy,
    output logic   req,
    output logic   ovr_set
);
    typedef struct packed {
        logic   prev;
        logic   en;
        sense_e mode;
        logic   req;
    } sense_st_t;

    sense_st_t st_d, st_q;
    logic cfg_chg, active, edge_seen;

    always_comb begin
        st_d      = st_q;
        cfg_chg   = (mode != st_q.mode) || (en != st_q.en);
        active    = (lvl_in == sense_active_val(mode));
        edge_seen = !cfg_chg && (st_q.prev != lvl_in) && active;
        st_d.prev = lvl_in;
        st_d.en   = en;
        st_d.mode = mode;
        if (sense_is_level(mode)) begin
            st_d.req = en && active;
            ovr_set  = 1'b0;
        end else begin
            st_d.req = en && edge_seen && !busy;
            ovr_set  = en && edge_seen && busy;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{prev: 1'b0, en: 1'b0, mode: SENSE_FALL, req: 1'b0};
        else        st_q <= st_d;
    end

    assign req = st_q.req;
endmodule

// File: rtl/trig_ovr_flag.sv
module trig_ovr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag
);
    typedef struct packed {
        logic flag;
    } ovr_st_t;

    ovr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_i)      st_d.flag = 1'b1;
        else if (clr_i) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;
endmodule

// File: rtl/ext_trig_det.sv
module ext_trig_det
    import ext_trig_pkg::*;
#(
    parameter int NUM_CH      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] pad_in,
    input  logic              trig_en,
    input  logic [1:0]        sense_sel,
    input  logic              seq_busy,
    input  logic              ovr_clr,
    output logic              start_req,
    output logic              ovr_flag
);
    localparam int TRIG_IDX = NUM_CH - 1;

    logic pin_sync;
    logic ovr_set;

    trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in[TRIG_IDX]),
        .sync_out (pin_sync)
    );

    trig_sense u_sense (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl_in  (pin_sync),
        .en      (trig_en),
        .mode    (sense_e'(sense_sel)),
        .busy    (seq_busy),
        .req     (start_req),
        .ovr_set (ovr_set)
    );

    trig_ovr_flag u_ovr (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (ovr_set),
        .clr_i (ovr_clr),
        .flag  (ovr_flag)
    );
endmodule

// File: rtl/ext_trig_det_chk.sv
module ext_trig_det_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       trig_en,
    input logic [1:0] sense_sel,
    input logic       seq_busy,
    input logic       ovr_clr,
    input logic       start_req,
    input logic       ovr_flag
);
    // R6: disabled trigger yields no request in the next cycle
    a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_en |=> !start_req);

    // R5: an edge-mode pulse is one cycle wide
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && !sense_sel[1]) |=> !start_req);

    // R7: an edge-mode start only when the sequencer was idle
    a_r7_idle_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && !$past(sense_sel[1])) |-> $past(!seq_busy));

    // R7: overrun rises only from a busy, enabled, edge-mode cycle
    a_r7_ovr_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_flag) |-> $past(seq_busy && trig_en && !sense_sel[1]));

    // R8: overrun stays set without a clear strobe
    a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !ovr_clr) |=> ovr_flag);
endmodule

bind ext_trig_det ext_trig_det_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_en   (trig_en),
    .sense_sel (sense_sel),
    .seq_busy  (seq_busy),
    .ovr_clr   (ovr_clr),
    .start_req (start_req),
    .ovr_flag  (ovr_flag)
);

// File: tb/ext_trig_det_bench.sv
`timescale 1ns/1ps
module ext_trig_det_bench;
    localparam int NUM_CH = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NUM_CH-1:0] pad_in = '0;
    logic              trig_en = 1'b0;
    logic [1:0]        sense_sel = 2'b01;
    logic              seq_busy = 1'b0;
    logic              ovr_clr = 1'b0;
    logic              start_req;
    logic              ovr_flag;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    ext_trig_det #(.NUM_CH(NUM_CH)) u_ext_trig_det (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .trig_en(trig_en),
        .sense_sel(sense_sel), .seq_busy(seq_busy), .ovr_clr(ovr_clr),
        .start_req(start_req), .ovr_flag(ovr_flag)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // advance n rising edges, then stop on the following falling edge
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_pin(input logic v);
        pad_in[NUM_CH-1] = v;
    endtask

    task automatic t_reset();
        chk("R1 start_req", start_req, 1'b0);
        chk("R1 ovr_flag", ovr_flag, 1'b0);
    endtask

    task automatic t_rise();
        sense_sel = 2'b01; trig_en = 1'b1; set_pin(1'b0); tick(4);
        set_pin(1'b1);
        tick(2); chk("R2 not yet", start_req, 1'b0);
        tick(1); chk("R2 pulse", start_req, 1'b1);
        tick(1); chk("R5 one cycle", start_req, 1'b0);
        set_pin(1'b0);
        tick(3); chk("R2 falling ignored", start_req, 1'b0);
    endtask

    task automatic t_fall();
        sense_sel = 2'b00; tick(4);
        set_pin(1'b1);
        tick(3); chk("R3 rising ignored", start_req, 1'b0);
        tick(2);
        set_pin(1'b0);
        tick(3); chk("R3 falling pulse", start_req, 1'b1);
        tick(1); chk("R3 pulse ends", start_req, 1'b0);
    endtask

    task automatic t_level();
        sense_sel = 2'b11; tick(3);
        chk("R4 high idle", start_req, 1'b0);
        set_pin(1'b1);
        tick(3); chk("R4 high asserted", start_req, 1'b1);
        seq_busy = 1'b1;
        tick(5); chk("R4 held while busy", start_req, 1'b1);
        chk("R4 no overrun in level", ovr_flag, 1'b0);
        seq_busy = 1'b0;
        set_pin(1'b0);
        tick(3); chk("R4 high drops", start_req, 1'b0);
        sense_sel = 2'b10;
        tick(1); chk("R4 low asserted", start_req, 1'b1);
        set_pin(1'b1);
        tick(3); chk("R4 low drops", start_req, 1'b0);
    endtask

    task automatic t_disable();
        bit seen = 0;
        sense_sel = 2'b01; set_pin(1'b0); tick(4);
        trig_en = 1'b0; seq_busy = 1'b1;
        set_pin(1'b1);
        for (int i = 0; i < 6; i++) begin
            tick(1);
            if (start_req) seen = 1;
        end
        chk("R6 no start disabled", seen, 1'b0);
        chk("R6 no overrun disabled", ovr_flag, 1'b0);
        seq_busy = 1'b0;
        trig_en = 1'b1;
        seen = 0;
        for (int i = 0; i < 4; i++) begin
            tick(1);
            if (start_req) seen = 1;
        end
        chk("R6 enable at active level", seen, 1'b0);
    endtask

    task automatic t_overrun();
        sense_sel = 2'b01; set_pin(1'b0); tick(4);
        seq_busy = 1'b1;
        set_pin(1'b1);
        tick(3);
        chk("R7 no start when busy", start_req, 1'b0);
        chk("R7 overrun set", ovr_flag, 1'b1);
        tick(4); chk("R8 sticky", ovr_flag, 1'b1);
        ovr_clr = 1'b1; tick(1); ovr_clr = 1'b0;
        chk("R8 cleared", ovr_flag, 1'b0);
        set_pin(1'b0); tick(4);
        set_pin(1'b1);
        tick(2); ovr_clr = 1'b1;
        tick(1); ovr_clr = 1'b0;
        chk("R8 set wins over clear", ovr_flag, 1'b1);
        ovr_clr = 1'b1; tick(1); ovr_clr = 1'b0;
        seq_busy = 1'b0;
        chk("R8 cleared again", ovr_flag, 1'b0);
    endtask

    task automatic t_mode_change();
        bit seen = 0;
        sense_sel = 2'b00; set_pin(1'b0); tick(4);
        set_pin(1'b1);
        tick(2);
        sense_sel = 2'b01;
        for (int i = 0; i < 4; i++) begin
            tick(1);
            if (start_req) seen = 1;
        end
        chk("R9 no spurious edge", seen, 1'b0);
    endtask

    task automatic t_other_pads();
        bit seen = 0;
        sense_sel = 2'b01; set_pin(1'b0); tick(4);
        for (int i = 0; i < 6; i++) begin
            pad_in[NUM_CH-2:0] = (i % 2 == 0) ? '1 : '0;
            tick(1);
            if (start_req) seen = 1;
        end
        chk("R10 low pads ignored", seen, 1'b0);
    endtask

    initial begin
        #4_000_000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        tick(2);
        t_reset();
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_rise();
        t_fall();
        t_level();
        t_disable();
        t_overrun();
        t_mode_change();
        t_other_pads();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule